// File: doc/BRIEF.md
# Status Register and Write-Protection Gate

This unit sits beside the command engine of a serial nonvolatile memory. It keeps the persistent status bits: a hardware-lock enable and a two-bit block-protect level. It assembles the byte that a status-read command shifts out. For every write request it decides, combinationally, whether the write may proceed. A request is either an array byte write at a given address or a status-register write. The unit is told the current write-enable latch, the busy flag, the active-low chip select and the active-low write-protect pin.

A status-write data byte arrives as a one-cycle `sr_wdata_vld` pulse. The flow has no ready signal and so no back-pressure. The byte is taken in the pulse cycle if a status write is permitted at that moment, and dropped otherwise. A taken byte is held while chip select stays low. It is discarded if the write-protect pin falls during that time with the lock enable set. Chip select rising arms it, and it is written into the register when `cycle_done` pulses at the end of the internal write cycle. An armed byte is no longer affected by the pin.

Top module: `wrprot_status_unit`

## Requirements
- R1: When `busy` is 0, `status_byte` is {lock enable, 3'b000, BP[1], BP[0], `wel`, 1'b0}: bit 7 is lock enable, bits 3:2 are the protect level and bit 1 is the latch.
- R2: When `busy` is 1, `status_byte` is 8'hFF and `permit` is 0 for both request kinds.
- R3: After reset the lock enable and the protect level are 0, so with `wel`=0 the status byte is 8'h00.
- R4: With ADDR_W=10, an array write (`req_kind`=0) is blocked at these addresses: none for level 0, 0x300..0x3FF for level 1, 0x200..0x3FF for level 2, and every address for level 3.
- R5: Any write, array or status, needs `wel`=1; with `wel`=0 `permit` is 0.
- R6: With lock enable 1 and `wp_n` 0, status writes (`req_kind`=1) are blocked. Array writes outside the protected range stay permitted.
- R7: With lock enable 0, `wp_n` has no effect on `permit` or on whether a status byte is taken.
- R8: A taken status byte changes the register only on the `cycle_done` pulse after `cs_n` has risen. Only bits 7, 3 and 2 are taken, and the other data bits are ignored.
- R9: If `wp_n` falls while `cs_n` is low after a byte was taken, and lock enable is 1, the byte is discarded. A fall after `cs_n` has risen has no effect.
- R10: A status byte offered while a status write is not permitted is dropped, and no later `cycle_done` changes the register.
- R11: `permit` follows `req_addr`, `req_kind`, `wel`, `busy` and `wp_n` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| wel | input | 1 | Write-enable latch from the command engine |
| busy | input | 1 | Internal write cycle in progress |
| req_addr | input | ADDR_W | Target address of an array write request |
| req_kind | input | 1 | 0 = array byte write, 1 = status write |
| permit | output | 1 | Request may proceed |
| sr_wdata_vld | input | 1 | Status data byte present (one-cycle pulse, no ready) |
| sr_wdata | input | 8 | Status data byte |
| cycle_done | input | 1 | Pulse at the end of the internal write cycle |
| status_byte | output | 8 | Byte returned by a status read |

## Verification
The bench probes the exact protect boundaries: 0x2FF against 0x300, 0x1FF against 0x200, 0x000 and 0x3FF. A decoder off by one quarter would let the first protected byte be written or block the last free one. It drops `wp_n` on both sides of the chip-select rise. A design that cancelled too late would commit a byte it should have discarded, and one that checked the pin at commit time would lose an armed update. It writes all-ones data and checks the status read-back. A design that stored the unused bits or the latch bits would return them. It also refuses bytes with the latch clear or under lock, then pulses `cycle_done` to catch a design that applied a stale byte.

// File: rtl/wps_pkg.sv
package wps_pkg;
  localparam int SR_W      = 8;
  localparam int SR_LOCK   = 7;
  localparam int SR_LVL_HI = 3;
  localparam int SR_LVL_LO = 2;
  localparam int SR_LATCH  = 1;
  localparam int SR_BUSY   = 0;
  localparam logic [SR_W-1:0] SR_WR_MASK = 8'h8C;
  localparam logic KIND_ARRAY  = 1'b0;
  localparam logic KIND_STATUS = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STAGED = 2'd1,
    ST_ARMED  = 2'd2
  } stage_t;
endpackage

// File: rtl/wps_range_decode.sv
module wps_range_decode #(
  parameter int ADDR_W = 10
) (
  input  logic [1:0]        level,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  localparam int SHIFT = ADDR_W - 2;

  logic [2:0]      first_q;   // first protected quarter, 4 = none
  logic [ADDR_W:0] bound;

  always_comb begin
    case (level)
      2'd0:    first_q = 3'd4;
      2'd1:    first_q = 3'd3;
      2'd2:    first_q = 3'd2;
      default: first_q = 3'd0;
    endcase
    bound  = (ADDR_W+1)'(first_q) << SHIFT;
    locked = ({1'b0, addr} >= bound);
  end
endmodule

// File: rtl/wps_sr_store.sv
module wps_sr_store
  import wps_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            wp_n,
  input  logic            wr_ok,
  input  logic            wdata_vld,
  input  logic [SR_W-1:0] wdata,
  input  logic            cycle_done,
  output logic [SR_W-1:0] sr_bits
);
  stage_t          st;
  logic [SR_W-1:0] hold;
  logic            cs_q, wp_q;
  logic            cs_rise, abort;

  assign cs_rise = cs_n & ~cs_q;
  assign abort   = ~wp_n & wp_q & ~cs_n & sr_bits[SR_LOCK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      hold    <= '0;
      sr_bits <= '0;
      cs_q    <= 1'b1;
      wp_q    <= 1'b1;
    end else begin
      cs_q <= cs_n;
      wp_q <= wp_n;
      case (st)
        ST_IDLE: begin
          if (wdata_vld && wr_ok) begin
            hold <= wdata & SR_WR_MASK;
            st   <= ST_STAGED;
          end
        end
        ST_STAGED: begin
          if (abort)        st <= ST_IDLE;
          else if (cs_rise) st <= ST_ARMED;
        end
        ST_ARMED: begin
          if (cycle_done) begin
            sr_bits <= hold;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  sr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st == ST_ARMED && cycle_done) |=> $stable(sr_bits));

  // R9
  wp_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STAGED && !cs_n && sr_bits[SR_LOCK] && $fell(wp_n)) |=> (st == ST_IDLE));

  // R9
  armed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARMED && !cycle_done) |=> (st == ST_ARMED));
endmodule

// File: rtl/wrprot_status_unit.sv
module wrprot_status_unit
  import wps_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              wel,
  input  logic              busy,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_kind,
  output logic              permit,
  input  logic              sr_wdata_vld,
  input  logic [SR_W-1:0]   sr_wdata,
  input  logic              cycle_done,
  output logic [SR_W-1:0]   status_byte
);
  logic [SR_W-1:0] sr_bits;
  logic            locked, hw_lock, status_ok, array_ok;

  wps_range_decode #(.ADDR_W(ADDR_W)) u_dec (
    .level  (sr_bits[SR_LVL_HI:SR_LVL_LO]),
    .addr   (req_addr),
    .locked (locked)
  );

  assign hw_lock   = sr_bits[SR_LOCK] & ~wp_n;
  assign status_ok = wel & ~busy & ~hw_lock;
  assign array_ok  = wel & ~busy & ~locked;
  assign permit    = (req_kind == KIND_STATUS) ? status_ok : array_ok;

  wps_sr_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .wp_n       (wp_n),
    .wr_ok      (status_ok),
    .wdata_vld  (sr_wdata_vld),
    .wdata      (sr_wdata),
    .cycle_done (cycle_done),
    .sr_bits    (sr_bits)
  );

  always_comb begin
    status_byte = sr_bits;
    status_byte[SR_LATCH] = wel;
    status_byte[SR_BUSY]  = 1'b0;
    if (busy) status_byte = '1;
  end

  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !permit);

  // R4
  range_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == KIND_ARRAY && locked) |-> !permit);

  // R6
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == KIND_STATUS && sr_bits[SR_LOCK] && !wp_n) |-> !permit);

  // R1
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (status_byte[6:4] == 3'b000 && status_byte[SR_BUSY] == 1'b0));
endmodule

// File: tb/wrprot_status_unit_test.sv
module wrprot_status_unit_test;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wp_n = 1'b1, wel = 1'b0, busy = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_kind = 1'b0;
  logic permit;
  logic sr_wdata_vld = 1'b0;
  logic [7:0] sr_wdata = '0;
  logic cycle_done = 1'b0;
  logic [7:0] status_byte;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit       m_lock = 0;
  bit [1:0] m_lvl  = 0;

  always #2 clk = ~clk;

  wrprot_status_unit #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .wel(wel), .busy(busy),
    .req_addr(req_addr), .req_kind(req_kind), .permit(permit),
    .sr_wdata_vld(sr_wdata_vld), .sr_wdata(sr_wdata), .cycle_done(cycle_done),
    .status_byte(status_byte)
  );

  function automatic bit m_locked(logic [AW-1:0] a);
    case (m_lvl)
      2'd0: return 1'b0;
      2'd1: return a[AW-1:AW-2] == 2'b11;
      2'd2: return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit m_permit(logic k, logic [AW-1:0] a, logic we, logic bz, logic wp);
    if (bz || !we) return 1'b0;
    if (k) return !(m_lock && !wp);
    return !m_locked(a);
  endfunction

  function automatic logic [7:0] m_status(logic we, logic bz);
    if (bz) return 8'hFF;
    return {m_lock, 3'b000, m_lvl, we, 1'b0};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic probe(string req, logic k, logic [AW-1:0] a, logic we, logic bz, logic wp);
    tick;
    req_kind = k; req_addr = a; wel = we; busy = bz; wp_n = wp;
    #1;
    chk(req, {7'd0, permit}, {7'd0, m_permit(k, a, we, bz, wp)});
    chk(req, status_byte, m_status(we, bz));
  endtask

  task automatic wrsr(string req, logic [7:0] d, logic we, logic wp_at, bit fall_low, bit fall_after);
    bit acc, cancel;
    cancel = 0;
    tick; cs_n = 0; wel = we; wp_n = wp_at; busy = 0;
    tick; sr_wdata = d; sr_wdata_vld = 1;
    acc = we && !(m_lock && !wp_at);
    tick; sr_wdata_vld = 0; wel = 0;
    if (fall_low) begin
      wp_n = 0;
      cancel = wp_at && m_lock;
      tick;
    end
    tick; cs_n = 1;
    tick;
    if (fall_after) begin wp_n = 0; tick; end
    #1;
    chk("R8 before done", status_byte, m_status(1'b0, 1'b0));
    busy = 1;
    tick; cycle_done = 1;
    #1;
    chk("R2 busy read", status_byte, 8'hFF);
    tick; cycle_done = 0; busy = 0;
    tick; wp_n = 1;
    if (acc && !cancel) begin
      m_lock = d[7];
      m_lvl  = d[3:2];
    end
    #1;
    chk(req, status_byte, m_status(1'b0, 1'b0));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) tick;
    #1;
    chk("R3 reset status", status_byte, 8'h00);
    rst_n = 1;

    probe("R4 level0 top", 1'b0, 10'h3FF, 1'b1, 1'b0, 1'b1);
    probe("R5 no latch array", 1'b0, 10'h010, 1'b0, 1'b0, 1'b1);
    probe("R5 no latch status", 1'b1, 10'h000, 1'b0, 1'b0, 1'b1);
    probe("R1 latch shown", 1'b0, 10'h000, 1'b1, 1'b0, 1'b1);
    probe("R2 busy blocks", 1'b1, 10'h000, 1'b1, 1'b1, 1'b1);

    wrsr("R8 mask all-ones", 8'hFF, 1'b1, 1'b1, 0, 0);
    chk("R8 mask value", status_byte, 8'h8C);
    probe("R4 level3 low", 1'b0, 10'h000, 1'b1, 1'b0, 1'b1);

    wrsr("R8 level1", 8'h84, 1'b1, 1'b1, 0, 0);
    probe("R4 level1 0x2FF", 1'b0, 10'h2FF, 1'b1, 1'b0, 1'b1);
    probe("R4 level1 0x300", 1'b0, 10'h300, 1'b1, 1'b0, 1'b1);
    probe("R6 hw lock status", 1'b1, 10'h000, 1'b1, 1'b0, 1'b0);
    probe("R6 hw lock free array", 1'b0, 10'h000, 1'b1, 1'b0, 1'b0);

    wrsr("R10 refused under lock", 8'h00, 1'b1, 1'b0, 0, 0);
    wrsr("R9 cancel cs low", 8'h88, 1'b1, 1'b1, 1, 0);
    wrsr("R9 armed keeps", 8'h88, 1'b1, 1'b1, 0, 1);
    probe("R4 level2 0x1FF", 1'b0, 10'h1FF, 1'b1, 1'b0, 1'b1);
    probe("R4 level2 0x200", 1'b0, 10'h200, 1'b1, 1'b0, 1'b1);

    wrsr("R8 unlock", 8'h08, 1'b1, 1'b1, 0, 0);
    probe("R7 pin ignored", 1'b1, 10'h000, 1'b1, 1'b0, 1'b0);
    wrsr("R7 taken with pin low", 8'h04, 1'b1, 1'b0, 0, 0);
    wrsr("R10 refused no latch", 8'h8C, 1'b0, 1'b1, 0, 0);

    for (int i = 0; i < 60; i++) begin
      wrsr("R8 random update", 8'($urandom), 1'($urandom), 1'($urandom),
           bit'($urandom), bit'($urandom));
      for (int j = 0; j < 10; j++)
        probe("R11 random permit", 1'($urandom), AW'($urandom), 1'($urandom),
              ($urandom % 5) == 0, 1'($urandom));
    end

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule